// File: doc/BRIEF.md
# Ethernet destination address filter

This block sits on the receive byte stream of an Ethernet MAC and decides, from the destination address alone, whether the incoming frame should be kept. It watches the first six bytes of each frame. It compares them with the programmed station address and tests them against an all-ones broadcast pattern. It also folds them through a bit-serial CRC-32 whose top bits select one entry of a 64-bit multicast hash mask.

Three independent enables control acceptance: promiscuous, broadcast and multicast. The block issues a single-cycle decision strobe. The strobe carries an accept bit and a flag that tells whether the destination was a group address. Every byte after the sixth is ignored until the next frame begins. A frame that ends before six bytes have arrived is rejected.

Top module: `dst_addr_filter`

## Requirements
- R1: When cfg_promisc is 1, every frame of six or more bytes is accepted, whatever its destination.
- R2: A destination of six 0xFF bytes is broadcast: is_group is 1, and without promiscuous mode the frame is accepted exactly when cfg_bcast_en is 1.
- R3: Any other destination whose first byte has bit 0 set is a group address: is_group is 1, and without promiscuous mode it is rejected whenever cfg_mcast_en is 0.
- R4: For a group address with cfg_mcast_en set, a CRC register is set to 0xFFFFFFFF and fed the six bytes in arrival order, each least significant bit first. For each bit, carry = CRC[31] XOR data bit; the CRC shifts left by one; if carry is 1, the CRC is XORed with 0x04C11DB6 and bit 0 is then set to 1. The frame is accepted exactly when hash_mask[CRC[31:26]] is 1.
- R5: A destination with bit 0 of the first byte clear is accepted, outside promiscuous mode, only when frame byte k equals station_addr[8k+7:8k] for every k from 0 to 5. In that case is_group is 0.
- R6: decision_valid is a one-cycle pulse that appears in the clock cycle after the sixth byte is taken. accept and is_group are meaningful only with it and are 0 in every other cycle.
- R7: Bytes that follow the sixth byte, and bytes with byte_first low that arrive while no frame is in progress, produce no decision.
- R8: A frame whose byte_last byte comes before its sixth byte gives decision_valid one cycle after that byte, with accept 0 and is_group 0, even in promiscuous mode.
- R9: While rst_n is low, decision_valid, accept and is_group are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A frame byte is present on byte_data this cycle |
| byte_first | input | 1 | Present byte is the first of a frame |
| byte_last | input | 1 | Present byte is the last of a frame |
| byte_data | input | 8 | Received frame byte |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_bcast_en | input | 1 | Accept broadcast frames |
| cfg_mcast_en | input | 1 | Allow group frames to reach the hash check |
| station_addr | input | 48 | Own address, byte k in bits 8k+7:8k |
| hash_mask | input | 64 | Multicast hash mask, indexed by CRC bits 31:26 |
| decision_valid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame is accepted (with decision_valid) |
| is_group | output | 1 | Destination is a group address (with decision_valid) |

## Verification
The assertions check the timing on every cycle. They confirm that accept and is_group never appear without the strobe, that the strobe always follows an accepted byte, that a one-byte frame always yields a rejecting decision on the next cycle, and that reset silences the outputs. The bench scenarios cover the classification itself: station address matching, hash-bit selection, the separate enables, the precedence of promiscuous mode, and the suppression of trailing and stray bytes. The bench checks these against a behavioural model of the CRC and the filter rules.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB6;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    typedef struct packed {
        logic valid;
        logic accept;
        logic group;
    } decision_t;
endpackage

// File: rtl/daf_crc_byte.sv
module daf_crc_byte
    import daf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    // Eight serial steps unrolled into one combinational stage, LSB first.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_i;
        for (int j = 0; j < DATA_W; j++) begin
            fb = c[CRC_W-1] ^ data_i[j];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) begin
                c = (c ^ CRC_POLY) | {{(CRC_W-1){1'b0}}, 1'b1};
            end
        end
        crc_o = c;
    end
endmodule

// File: rtl/daf_classify.sv
module daf_classify #(
    parameter int HASH_BITS = 6,
    localparam int MASK_W = 1 << HASH_BITS
) (
    input  logic                 promisc_i,
    input  logic                 bcast_en_i,
    input  logic                 mcast_en_i,
    input  logic                 is_bcast_i,
    input  logic                 is_group_i,
    input  logic                 uc_match_i,
    input  logic [HASH_BITS-1:0] hash_idx_i,
    input  logic [MASK_W-1:0]    hash_mask_i,
    output logic                 accept_o
);
    always_comb begin
        if (promisc_i) begin
            accept_o = 1'b1;
        end else if (is_bcast_i) begin
            accept_o = bcast_en_i;
        end else if (is_group_i) begin
            accept_o = mcast_en_i & hash_mask_i[hash_idx_i];
        end else begin
            accept_o = uc_match_i;
        end
    end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int ADDR_W = ADDR_BYTES * 8,
    localparam int MASK_W = 1 << HASH_BITS,
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic              byte_first,
    input  logic              byte_last,
    input  logic [7:0]        byte_data,
    input  logic              cfg_promisc,
    input  logic              cfg_bcast_en,
    input  logic              cfg_mcast_en,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [MASK_W-1:0] hash_mask,
    output logic              decision_valid,
    output logic              accept,
    output logic              is_group
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic             bcast;
        logic             ucast;
        logic             group;
        decision_t        dec;
    } state_t;

    state_t st_d, st_q;

    logic             take_first, take_next;
    logic [CNT_W-1:0] pos, pos_nx;
    logic [CRC_W-1:0] crc_in, crc_nx;
    logic [7:0]       own_byte;
    logic             bcast_nx, ucast_nx, group_nx, cls_accept;

    assign take_first = byte_valid & byte_first;
    assign take_next  = byte_valid & ~byte_first & st_q.active;
    assign pos        = take_first ? '0 : st_q.cnt;
    assign pos_nx     = pos + CNT_W'(1);
    assign crc_in     = take_first ? CRC_SEED : st_q.crc;
    assign own_byte   = station_addr[{pos, 3'b000} +: 8];
    assign bcast_nx   = (take_first | st_q.bcast) & (byte_data == 8'hFF);
    assign ucast_nx   = (take_first | st_q.ucast) & (byte_data == own_byte);
    assign group_nx   = take_first ? byte_data[0] : st_q.group;

    daf_crc_byte #(.DATA_W(8)) crc_i (
        .crc_i  (crc_in),
        .data_i (byte_data),
        .crc_o  (crc_nx)
    );

    daf_classify #(.HASH_BITS(HASH_BITS)) cls_i (
        .promisc_i   (cfg_promisc),
        .bcast_en_i  (cfg_bcast_en),
        .mcast_en_i  (cfg_mcast_en),
        .is_bcast_i  (bcast_nx),
        .is_group_i  (group_nx),
        .uc_match_i  (ucast_nx),
        .hash_idx_i  (crc_nx[CRC_W-1 -: HASH_BITS]),
        .hash_mask_i (hash_mask),
        .accept_o    (cls_accept)
    );

    always_comb begin
        st_d     = st_q;
        st_d.dec = '0;
        if (take_first || take_next) begin
            st_d.active = 1'b1;
            st_d.cnt    = pos_nx;
            st_d.crc    = crc_nx;
            st_d.bcast  = bcast_nx;
            st_d.ucast  = ucast_nx;
            st_d.group  = group_nx;
            if (pos_nx == LAST_POS) begin
                st_d.active     = 1'b0;
                st_d.dec.valid  = 1'b1;
                st_d.dec.accept = cls_accept;
                st_d.dec.group  = group_nx;
            end else if (byte_last) begin
                st_d.active    = 1'b0;
                st_d.dec.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign decision_valid = st_q.dec.valid;
    assign accept         = st_q.dec.accept;
    assign is_group       = st_q.dec.group;
endmodule

// File: rtl/dst_addr_filter_chk.sv
module dst_addr_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic byte_valid,
    input logic byte_first,
    input logic byte_last,
    input logic decision_valid,
    input logic accept,
    input logic is_group
);
    // R6
    accept_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept | is_group) |-> decision_valid);

    // R6
    strobe_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |-> $past(byte_valid));

    // R8
    one_byte_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_first && byte_last) |=> (decision_valid && !accept && !is_group));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!decision_valid && !accept && !is_group));
endmodule

bind dst_addr_filter dst_addr_filter_chk chk_i (.*);

// File: tb/dst_addr_filter_tb.sv
module dst_addr_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0, byte_first = 1'b0, byte_last = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        cfg_promisc = 1'b0, cfg_bcast_en = 1'b0, cfg_mcast_en = 1'b0;
    logic [47:0] station_addr = 48'h0;
    logic [63:0] hash_mask = 64'h0;
    logic        decision_valid, accept, is_group;

    int errors = 0;
    int checks = 0;
    logic [7:0] fr[$];

    always #2 clk = ~clk;

    dst_addr_filter dut_i (.*);

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc();
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < 6; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic cy = c[31] ^ fr[k][b];
                c = c << 1;
                if (cy) c = (c ^ 32'h04C11DB6) | 32'h1;
            end
        end
        return c;
    endfunction

    function automatic logic ref_is_group();
        return fr.size() >= 6 && fr[0][0];
    endfunction

    function automatic logic ref_accept();
        logic bc = 1'b1, uc = 1'b1;
        int idx;
        if (fr.size() < 6) return 1'b0;
        if (cfg_promisc) return 1'b1;
        for (int k = 0; k < 6; k++) begin
            if (fr[k] != 8'hFF) bc = 1'b0;
            if (fr[k] != station_addr[8*k +: 8]) uc = 1'b0;
        end
        if (bc) return cfg_bcast_en;
        if (fr[0][0]) begin
            idx = int'(ref_crc() >> 26);
            return cfg_mcast_en && hash_mask[idx];
        end
        return uc;
    endfunction

    // Drive frame in fr; compare outputs against the model every cycle.
    task automatic send_frame(string tag);
        int n = fr.size();
        int at = (n < 6) ? n : 6;
        logic ea = ref_accept();
        logic eg = ref_is_group();
        for (int i = 0; i <= n + 1; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk(tag, "R6 decision_valid", decision_valid, i == at);
                chk(tag, "accept", accept, (i == at) ? ea : 1'b0);
                chk(tag, "is_group", is_group, (i == at) ? eg : 1'b0);
            end
            byte_valid = (i < n);
            byte_first = (i == 0);
            byte_last  = (i == n - 1);
            byte_data  = (i < n) ? fr[i] : 8'h00;
        end
    endtask

    task automatic load(logic [47:0] a, int extra);
        fr.delete();
        for (int k = 0; k < 6; k++) fr.push_back(a[8*k +: 8]);
        for (int k = 0; k < extra; k++) fr.push_back(8'(k * 37 + 5));
    endtask

    initial begin
        int idx;
        station_addr = 48'h66_55_44_33_22_12;
        repeat (3) @(negedge clk);
        chk("R9", "decision_valid in reset", decision_valid, 1'b0);
        chk("R9", "accept in reset", accept, 1'b0);
        rst_n = 1'b1;

        // R5 unicast match and mismatch
        load(station_addr, 2);                   send_frame("R5 match");
        load(station_addr ^ 48'h01_00_00_00_00_00, 0); send_frame("R5 last-byte miss");
        load(station_addr ^ 48'h00_00_00_00_01_00, 0); send_frame("R5 second-byte miss");

        // R2 broadcast
        cfg_bcast_en = 1'b1; load(48'hFFFF_FFFF_FFFF, 4); send_frame("R2 bcast on");
        cfg_bcast_en = 1'b0; load(48'hFFFF_FFFF_FFFF, 0); send_frame("R2 bcast off");

        // R3 / R4 multicast
        load(48'h01_00_00_5E_00_01, 0);
        idx = int'(ref_crc() >> 26);
        hash_mask = '1; cfg_mcast_en = 1'b0; send_frame("R3 mcast disabled");
        cfg_mcast_en = 1'b1;                 send_frame("R3 mcast all-ones mask");
        hash_mask = 64'h1 << idx;            send_frame("R4 selected hash bit");
        hash_mask = ~(64'h1 << idx);         send_frame("R4 other hash bits");
        load(48'h33_00_00_00_00_33, 1);
        hash_mask = 64'h1 << (ref_crc() >> 26); send_frame("R4 second address");

        // R1 promiscuous overrides everything
        cfg_promisc = 1'b1; cfg_mcast_en = 1'b0; hash_mask = '0;
        load(48'hA1_B2_C3_D4_E5_F6, 0); send_frame("R1 promisc unicast");
        load(48'hA1_B2_C3_D4_E5_F7, 0); send_frame("R1 promisc group");

        // R8 short frames, even promiscuous
        fr.delete(); fr.push_back(8'h12); fr.push_back(8'h22); fr.push_back(8'h33);
        send_frame("R8 three bytes");
        fr.delete(); fr.push_back(8'hFF); send_frame("R8 one byte");
        cfg_promisc = 1'b0;

        // R7 long frame trailing bytes, then stray bytes while idle
        load(station_addr, 9); send_frame("R7 long frame");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i > 0) chk("R7 stray", "R7 decision_valid", decision_valid, 1'b0);
            byte_valid = (i < 6); byte_first = 1'b0; byte_last = (i == 5);
            byte_data = 8'(i + 8'h12);
        end
        load(station_addr, 0); send_frame("R5 after stray");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule